// File: doc/BRIEF.md
# Configuration Port Transfer Bridge

This block lets a processor move a configuration bitstream through an internal configuration port, in either direction, using a plain register strobe interface. Software first programs a word count. It then either pushes words into a small outbound queue and starts a write transfer, or starts a readback and later pops the captured words from a small inbound queue. While a transfer runs, a sequencer drives the port's active-low enable and active-low write-select lines and presents outbound data. It also watches the port's busy input, and every cycle with busy high holds the transfer where it is.

The command register clears itself. Hardware drops the start bits two cycles after a one-cycle end pulse. An abort bit stops everything at once and discards whatever is queued. The status "done" flag only says that the port is not being driven. It does not say whether the transfer achieved anything.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the command register reads 0, the count register reads 0, the status register reads exactly 0x1, and both `cp_en_n` and `cp_wr_n` are 1.
- R2: Writing a value whose bits [1:0] are 01 and whose bit 27 is 0 to the command register (address 0) starts a write transfer. The words pushed earlier through address 3 appear on `cp_dout` in push order. Each one is handed over on a cycle where `cp_en_n`=0, `cp_wr_n`=0 and `cp_busy`=0.
- R3: Writing a value whose bits [1:0] are 10 to the command register starts a readback with `cp_en_n`=0 and `cp_wr_n`=1. `cp_din` is captured on every cycle with `cp_busy`=0. Reads of address 3 with `reg_rd`=1 return the captured words in order.
- R4: The count register (address 2) drops by exactly one for each word transferred and holds on any cycle with `cp_busy`=1. A transfer ends when the count reaches 0, and a start with a count of 0 ends without asserting `cp_en_n`.
- R5: Each completed transfer raises `op_end` for exactly one cycle. The command register still reads non-zero in that cycle and in the next one, and reads 0 from the cycle after that.
- R6: Status bit 0 (done) is 0 while a transfer is moving data or waiting on the port, and 1 otherwise.
- R7: A start command written while the command register is non-zero leaves it unchanged. A command whose bits [1:0] are 11 or 00 starts nothing. A count write made while the command register is non-zero is ignored.
- R8: Writing a command with bit 27 set aborts. On the next cycle `cp_en_n`=1, both queues are empty, the count reads 0, the command register reads 0 and done is 1. Abort takes priority over a capture that happens in the same cycle.
- R9: `cp_wr_n` does not change while `cp_en_n` stays 0.
- R10: Status bit 1 is 1 when the inbound queue holds data, and status bit 2 is 1 when the outbound queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the inbound queue at address 3 |
| reg_addr | input | 2 | Register word address (0 command, 1 status, 2 count, 3 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cp_en_n | output | 1 | Port enable, active low |
| cp_wr_n | output | 1 | Port write select, low for write transfer |
| cp_dout | output | DW | Data toward the port |
| cp_din | input | DW | Data from the port |
| cp_busy | input | 1 | Port busy; stalls the transfer |
| op_end | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest overlap is an abort landing in the same cycle as a readback capture. It is provoked by issuing the abort write while the port is enabled and busy is low. It is judged by finding the inbound queue empty, the count at 0 and the command cleared on the next cycle. The second overlap is a start command arriving while a stalled transfer holds the command register. There the bench checks that the register keeps its readback value and that the count it loaded earlier is untouched.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

    localparam int REG_W          = 32;
    localparam int CMD_WR_BIT     = 0;
    localparam int CMD_RD_BIT     = 1;
    localparam int CMD_ABORT_BIT  = 27;

    typedef enum logic [1:0] {
        A_CMD  = 2'd0,
        A_STAT = 2'd1,
        A_CNT  = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_END,
        ST_CLR
    } xfer_state_e;

    typedef struct packed {
        logic go_rd;
        logic go_wr;
    } start_t;

    function automatic start_t decode_start(input logic [REG_W-1:0] w);
        start_t s;
        s.go_wr = (w[CMD_RD_BIT:CMD_WR_BIT] == 2'b01);
        s.go_rd = (w[CMD_RD_BIT:CMD_WR_BIT] == 2'b10);
        return s;
    endfunction

endpackage

// File: rtl/cpb_fifo.sv
module cpb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + CW'(1);
            else if (do_pop && !do_push) cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/cpb_xfer.sv
module cpb_xfer
    import cpb_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  start_t            start,
    input  logic              abort,
    input  logic              cnt_ld,
    input  logic [SIZE_W-1:0] cnt_din,
    input  logic              src_avail,
    input  logic              dst_room,
    input  logic              port_busy,
    output logic [SIZE_W-1:0] cnt_q,
    output logic              port_en_n,
    output logic              port_wr_n,
    output logic              beat_wr,
    output logic              beat_rd,
    output logic              end_pulse,
    output logic              clr_cmd,
    output logic              idle
);
    xfer_state_e state_q;
    logic        drive_wr, drive_rd, beat, last;

    assign drive_wr  = (state_q == ST_WRITE) && (cnt_q != '0) && src_avail;
    assign drive_rd  = (state_q == ST_READ)  && (cnt_q != '0) && dst_room;
    assign port_en_n = !(drive_wr || drive_rd);
    assign port_wr_n = (state_q != ST_WRITE);
    assign beat      = !port_en_n && !port_busy;
    assign beat_wr   = beat && drive_wr;
    assign beat_rd   = beat && drive_rd;
    assign last      = (cnt_q == SIZE_W'(1));
    assign end_pulse = (state_q == ST_END);
    assign clr_cmd   = (state_q == ST_CLR);
    assign idle      = (state_q != ST_WRITE) && (state_q != ST_READ);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cnt_ld) cnt_q <= cnt_din;
                    if (start.go_wr)      state_q <= ST_WRITE;
                    else if (start.go_rd) state_q <= ST_READ;
                end
                ST_WRITE, ST_READ: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_END;
                    end else if (beat) begin
                        cnt_q <= cnt_q - SIZE_W'(1);
                        if (last) state_q <= ST_END;
                    end
                end
                ST_END:  state_q <= ST_CLR;
                ST_CLR:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cpb_pkg::*;
#(
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int SIZE_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             cp_en_n,
    output logic             cp_wr_n,
    output logic [DW-1:0]    cp_dout,
    input  logic [DW-1:0]    cp_din,
    input  logic             cp_busy,
    output logic             op_end
);
    reg_addr_e         addr;
    logic [1:0]        ctrl_q;
    logic              ctrl_wr, abort_hit, cnt_ld, clr_cmd, xfer_idle;
    start_t            start_raw, start_ok;
    logic [SIZE_W-1:0] size_cur;
    logic              beat_wr, beat_rd;
    logic              wq_empty, wq_full, rq_empty, rq_full;
    logic [DW-1:0]     rq_dout;

    assign addr      = reg_addr_e'(reg_addr);
    assign ctrl_wr   = reg_wr && (addr == A_CMD);
    assign abort_hit = ctrl_wr && reg_wdata[CMD_ABORT_BIT];
    assign start_raw = decode_start(reg_wdata);
    assign start_ok  = (ctrl_wr && !abort_hit && ctrl_q == '0) ? start_raw : '0;
    assign cnt_ld    = reg_wr && (addr == A_CNT) && (ctrl_q == '0);

    always_ff @(posedge clk) begin
        if (rst || abort_hit || clr_cmd) ctrl_q <= '0;
        else if (start_ok.go_wr)         ctrl_q <= 2'b01;
        else if (start_ok.go_rd)         ctrl_q <= 2'b10;
    end

    cpb_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_wq (
        .clk(clk), .rst(rst), .flush(abort_hit),
        .push(reg_wr && addr == A_DATA), .din(reg_wdata[DW-1:0]),
        .pop(beat_wr), .dout(cp_dout), .empty(wq_empty), .full(wq_full)
    );

    cpb_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rq (
        .clk(clk), .rst(rst), .flush(abort_hit),
        .push(beat_rd), .din(cp_din),
        .pop(reg_rd && addr == A_DATA), .dout(rq_dout), .empty(rq_empty), .full(rq_full)
    );

    cpb_xfer #(.SIZE_W(SIZE_W)) u_xfer (
        .clk(clk), .rst(rst), .start(start_ok), .abort(abort_hit),
        .cnt_ld(cnt_ld), .cnt_din(reg_wdata[SIZE_W-1:0]),
        .src_avail(!wq_empty), .dst_room(!rq_full), .port_busy(cp_busy),
        .cnt_q(size_cur), .port_en_n(cp_en_n), .port_wr_n(cp_wr_n),
        .beat_wr(beat_wr), .beat_rd(beat_rd), .end_pulse(op_end),
        .clr_cmd(clr_cmd), .idle(xfer_idle)
    );

    always_comb begin
        unique case (addr)
            A_CMD:   reg_rdata = REG_W'(ctrl_q);
            A_STAT:  reg_rdata = REG_W'({wq_full, !rq_empty, xfer_idle});
            A_CNT:   reg_rdata = REG_W'(size_cur);
            A_DATA:  reg_rdata = REG_W'(rq_dout);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpb_chk.sv
module cpb_chk #(
    parameter int SIZE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cp_en_n,
    input logic              cp_wr_n,
    input logic              cp_busy,
    input logic [1:0]        ctrl_q,
    input logic [SIZE_W-1:0] size_cur,
    input logic              abort_hit,
    input logic              ctrl_wr,
    input logic              op_end,
    input logic              xfer_idle
);
    // R9
    wr_sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!cp_en_n && !$past(cp_en_n)) |-> $stable(cp_wr_n));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!cp_en_n && !cp_busy && !abort_hit) |=> (size_cur == $past(size_cur) - SIZE_W'(1)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cp_en_n && cp_busy && !abort_hit) |=> $stable(size_cur));

    // R8
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        abort_hit |=> (cp_en_n && size_cur == '0 && ctrl_q == '0 && xfer_idle));

    // R5
    end_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        op_end |-> (ctrl_q != '0));

    // R5
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        op_end |=> !op_end);

    // R6
    done_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cp_en_n |-> !xfer_idle);

    // R7
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl_q));

    // R7
    cmd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !abort_hit && ctrl_q != '0) |=> (ctrl_q == $past(ctrl_q) || ctrl_q == '0));

endmodule

bind cfg_port_bridge cpb_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst(rst), .cp_en_n(cp_en_n), .cp_wr_n(cp_wr_n), .cp_busy(cp_busy),
    .ctrl_q(ctrl_q), .size_cur(size_cur), .abort_hit(abort_hit), .ctrl_wr(ctrl_wr),
    .op_end(op_end), .xfer_idle(xfer_idle)
);

// File: tb/cfg_port_bridge_bench.sv
`timescale 1ns/1ps
module cfg_port_bridge_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cp_en_n, cp_wr_n, op_end;
    logic [DW-1:0] cp_dout, cp_din;
    logic          cp_busy = 1'b0;

    int checks = 0, errors = 0;
    int wn = 0, rd_idx = 0, ends = 0, bad_pol = 0;
    int cyc = 0;
    logic [31:0] wlog [64];
    logic [7:0]  busy_mask = '0;
    logic        busy_force = 1'b0;
    logic        exp_wr_n = 1'b1;

    always #2.5 clk = ~clk;

    cfg_port_bridge u_cfg_port_bridge (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cp_en_n(cp_en_n), .cp_wr_n(cp_wr_n),
        .cp_dout(cp_dout), .cp_din(cp_din), .cp_busy(cp_busy), .op_end(op_end)
    );

    assign cp_din = 32'hC0DE_0000 + 32'(rd_idx);

    // port model
    always @(posedge clk) begin
        if (!rst) begin
            if (!cp_en_n && cp_wr_n != exp_wr_n) bad_pol <= bad_pol + 1;
            if (!cp_en_n && !cp_busy) begin
                if (!cp_wr_n) begin
                    if (wn < 64) wlog[wn] <= cp_dout;
                    wn <= wn + 1;
                end else begin
                    rd_idx <= rd_idx + 1;
                end
            end
            if (op_end) ends <= ends + 1;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        cp_busy <= busy_force | busy_mask[cyc[2:0]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic pop, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        if (pop) begin
            reg_rd = 1'b1;
            @(negedge clk);
            reg_rd = 1'b0;
        end
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        v = 32'hFFFF_FFFF;
        for (int i = 0; i < 300 && v != 0; i++) reg_read(2'd0, 1'b0, v);
        chk(req, v, 32'h0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // {dir(1=read), count[7:0], busy mask[7:0]}
    localparam logic [16:0] VEC [5] = '{
        {1'b0, 8'd3, 8'b0000_0000},
        {1'b1, 8'd3, 8'b0000_0000},
        {1'b0, 8'd5, 8'b0101_0010},
        {1'b1, 8'd4, 8'b1100_0001},
        {1'b1, 8'd8, 8'b0010_0100}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int wbase, rbase, ebase;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(2'd0, 1'b0, v); chk("R1 cmd", v, 32'h0);
        reg_read(2'd2, 1'b0, v); chk("R1 count", v, 32'h0);
        reg_read(2'd1, 1'b0, v); chk("R1 status", v, 32'h1);
        chk("R1 en_n", 32'(cp_en_n), 32'h1);
        chk("R1 wr_n", 32'(cp_wr_n), 32'h1);

        for (int v_i = 0; v_i < 5; v_i++) begin
            logic dir;
            int   cnt;
            dir = VEC[v_i][16];
            cnt = int'(VEC[v_i][15:8]);
            reg_write(2'd2, 32'(cnt));
            wbase = wn; rbase = rd_idx; ebase = ends;
            if (!dir) begin
                for (int k = 0; k < cnt; k++) reg_write(2'd3, 32'hA500_0000 + 32'(v_i * 256 + k));
                exp_wr_n = 1'b0;
                busy_mask = VEC[v_i][7:0];
                reg_write(2'd0, 32'h1);
            end else begin
                exp_wr_n = 1'b1;
                busy_mask = VEC[v_i][7:0];
                reg_write(2'd0, 32'h2);
            end
            wait_idle("R5 cmd clears");
            busy_mask = '0;
            chk("R5 one end pulse", 32'(ends - ebase), 32'h1);
            if (!dir) begin
                chk("R2 word count", 32'(wn - wbase), 32'(cnt));
                for (int k = 0; k < cnt; k++)
                    chk("R2 write data", wlog[wbase + k], 32'hA500_0000 + 32'(v_i * 256 + k));
            end else begin
                chk("R3 capture count", 32'(rd_idx - rbase), 32'(cnt));
                reg_read(2'd1, 1'b0, v); chk("R10 read data flag", v & 32'h2, 32'h2);
                for (int k = 0; k < cnt; k++) begin
                    reg_read(2'd3, 1'b1, v);
                    chk("R3 read data", v, 32'hC0DE_0000 + 32'(rbase + k));
                end
            end
            reg_read(2'd2, 1'b0, v); chk("R4 count at end", v, 32'h0);
            reg_read(2'd1, 1'b0, v); chk("R6 done after", v, 32'h1);
        end
        chk("R9 wr_n level during enable", 32'(bad_pol), 32'h0);

        // R4 stall, R6 done low, R7 start ignored while busy
        busy_force = 1'b1;
        reg_write(2'd2, 32'd4);
        exp_wr_n = 1'b1;
        reg_write(2'd0, 32'h2);
        repeat (5) @(negedge clk);
        reg_read(2'd2, 1'b0, v); chk("R4 stalled count", v, 32'd4);
        chk("R3 enable during read", 32'(cp_en_n), 32'h0);
        reg_read(2'd1, 1'b0, v); chk("R6 done low", v & 32'h1, 32'h0);
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, 1'b0, v); chk("R7 start ignored", v, 32'h2);
        reg_write(2'd2, 32'd9);
        reg_read(2'd2, 1'b0, v); chk("R7 count write ignored", v, 32'd4);
        // R8 abort on stalled read
        reg_write(2'd0, 32'h0800_0000);
        chk("R8 en_n after abort", 32'(cp_en_n), 32'h1);
        #1 reg_addr = 2'd0; #1 chk("R8 cmd after abort", reg_rdata, 32'h0);
        reg_read(2'd2, 1'b0, v); chk("R8 count after abort", v, 32'h0);
        reg_read(2'd1, 1'b0, v); chk("R8 status after abort", v, 32'h1);
        busy_force = 1'b0;

        // R8 abort in the same cycle as a capture
        reg_write(2'd2, 32'd6);
        reg_write(2'd0, 32'h2);
        rbase = rd_idx;
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 32'h0800_0000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 capture happened with abort", 32'(rd_idx - rbase > 0), 32'h1);
        reg_read(2'd1, 1'b0, v); chk("R8 inbound flushed", v, 32'h1);
        reg_read(2'd2, 1'b0, v); chk("R8 count zero", v, 32'h0);
        reg_read(2'd0, 1'b0, v); chk("R8 cmd zero", v, 32'h0);

        // R7 illegal start code
        reg_write(2'd0, 32'h3);
        reg_read(2'd0, 1'b0, v); chk("R7 code 11 ignored", v, 32'h0);
        chk("R7 no enable", 32'(cp_en_n), 32'h1);

        // R4 zero-count start
        wbase = wn; ebase = ends;
        reg_write(2'd2, 32'd0);
        exp_wr_n = 1'b0;
        reg_write(2'd0, 32'h1);
        wait_idle("R4 zero count ends");
        chk("R4 zero count no words", 32'(wn - wbase), 32'h0);
        chk("R5 zero count pulse", 32'(ends - ebase), 32'h1);

        // R10 outbound full, R8 abort flushes outbound
        for (int k = 0; k < 8; k++) reg_write(2'd3, 32'h7700_0000 + 32'(k));
        reg_read(2'd1, 1'b0, v); chk("R10 outbound full", v, 32'h5);
        reg_write(2'd0, 32'h0800_0000);
        reg_read(2'd1, 1'b0, v); chk("R8 outbound flushed", v, 32'h1);
        wbase = wn;
        reg_write(2'd2, 32'd2);
        reg_write(2'd0, 32'h1);
        repeat (6) @(negedge clk);
        chk("R8 nothing left to send", 32'(wn - wbase), 32'h0);
        reg_write(2'd0, 32'h0800_0000);

        // R5 exact end timing, single word write
        reg_write(2'd3, 32'h1234_5678);
        reg_write(2'd2, 32'd1);
        reg_write(2'd0, 32'h1);
        chk("R2 enable low", 32'(cp_en_n), 32'h0);
        chk("R2 wr_n low", 32'(cp_wr_n), 32'h0);
        chk("R2 data presented", cp_dout, 32'h1234_5678);
        chk("R5 no pulse yet", 32'(op_end), 32'h0);
        reg_addr = 2'd0;
        @(negedge clk);
        chk("R5 pulse", 32'(op_end), 32'h1);
        chk("R5 cmd held at pulse", reg_rdata, 32'h1);
        @(negedge clk);
        chk("R5 pulse gone", 32'(op_end), 32'h0);
        chk("R5 cmd held after pulse", reg_rdata, 32'h1);
        @(negedge clk);
        chk("R5 cmd cleared", reg_rdata, 32'h0);

        chk("R9 wr_n level overall", 32'(bad_pol), 32'h0);
        finish_run();
    end

endmodule